// File: doc/BRIEF.md
# Single-Layer Display Window Compositor

This block turns an externally supplied active-area pixel position into an output pixel stream for a display whose width and height are programmable. One rectangular frame-buffer layer sits inside the display at a programmable position. Pixels that fall inside the layer come from a fetched 32-bit word stream. Every other display pixel is painted opaque black. Display timing, the memory controller and the frame memory are outside the block.

Software programs a set of shadow registers. These cover the sizes, the layer position, the line stride, the base address, the byte order and the control bits. A load request arms a copy of the whole shadow set into the active set, and the copy happens at the next frame boundary. For every layer line the block issues one fetch request that carries the byte address of that line. The request is always issued one line before the line is needed. The fetched words come back on a ready/valid input and are consumed in raster order.

Top module: `lwc_top`

## Requirements
- R1: After reset, `out_valid`, `fetch_req_valid` and `underflow` are 0, and the active configuration has every enable cleared, so no pixel is produced until a configuration is loaded.
- R2: A write to register offsets 0..6 changes only the shadow copy. Writing offset 7 with bit 0 set arms a load. The armed copy takes effect at the next frame boundary, which is a strobed pixel with x=0 and y=0, and that boundary pixel already uses the new values.
- R3: Offset 1 holds the display size as (height-1) in [31:16] and (width-1) in [15:0]. `out_valid` rises one cycle after a strobed pixel that lies inside the display, and only for such pixels.
- R4: A display pixel outside the layer rectangle, or any pixel while the layer enable is clear, is output as 0xFF000000.
- R5: Control bit 4 selects the byte order of fetched words. With bit 4 at 0 the word is X,R,G,B from the top byte down, and the output is {0xFF, w[23:0]}. With bit 4 at 1 the word is B,G,R,X, and the output is {0xFF, w[15:8], w[23:16], w[31:24]}.
- R6: Offset 2 holds the layer size as (height-1) in [31:16] and (width-1) in [15:0]. Offset 3 holds the layer's top-left y in [31:16] and x in [15:0]. `px_in_ready` is high exactly for strobed pixels inside both the layer and the display, and each such pixel consumes one word.
- R7: Output needs control bit 0 (module on) and bit 2 (run) both set. Layer content needs bit 1 as well.
- R8: With control bit 3 set, the display shows twice the programmed height.
- R9: The base byte address is {offset 6 [3:0], offset 5 [31:3]}, and offset 4 is the stride in bits. A frame boundary with module, run and layer set issues a request for layer line 0 at the base. The final pixel of every layer line except the last issues a request for line n+1 at base + (n+1)*stride/8. A request stays asserted with its address unchanged until `fetch_req_ready` is seen.
- R10: A layer pixel with no valid input word is output as 0xFF000000 and sets `underflow`, which then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Active-area pixel strobe |
| pix_x | input | 16 | Pixel column |
| pix_y | input | 16 | Pixel row |
| fetch_req_valid | output | 1 | Line fetch request |
| fetch_req_ready | input | 1 | Request accepted |
| fetch_req_addr | output | 33 | Byte address of the requested line |
| px_in_valid | input | 1 | Fetched word available |
| px_in_ready | output | 1 | Word consumed this cycle |
| px_in_data | input | 32 | Fetched word |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 32 | Output pixel, ARGB |
| underflow | output | 1 | Sticky data-starvation flag |

## Verification
Two things can land on the same clock edge: the armed register copy at a frame boundary, and the line-0 fetch request that this boundary starts. The bench provokes this by changing the base address (including its high bits) and the stride in the shadow set, then arming a load. The request issued on the boundary edge must already carry the new base. A second case puts the layer at the display origin. There, the first layer pixel, the register copy and the line-0 request all share one cycle, and the pixel must come out black with `underflow` set. A cycle-exact behavioural model judges every output on every clock.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    localparam int DATA_W    = 32;
    localparam int CRD_W     = 16;
    localparam int ADDR_W    = 33;
    localparam int RADDR_W   = 3;
    localparam int FRAC_W    = 3;                       // bit-to-byte shift
    localparam int BASE_HI_W = ADDR_W - DATA_W + FRAC_W; // upper byte-address bits

    typedef enum logic [RADDR_W-1:0] {
        RG_CTRL    = 3'd0,
        RG_DSIZE   = 3'd1,
        RG_LSIZE   = 3'd2,
        RG_LPOS    = 3'd3,
        RG_STRIDE  = 3'd4,
        RG_BASE_LO = 3'd5,
        RG_BASE_HI = 3'd6,
        RG_LOAD    = 3'd7
    } reg_sel_e;

    // bit 0 module on, 1 layer on, 2 run, 3 interlace, 4 B,G,R,X order
    typedef struct packed {
        logic bgra;
        logic ilace;
        logic run;
        logic lay_en;
        logic mod_en;
    } ctrl_t;

    typedef struct packed {
        logic [CRD_W-1:0] hi;
        logic [CRD_W-1:0] lo;
    } pair_t;

    typedef struct packed {
        ctrl_t                 ctrl;
        pair_t                 dsize;
        pair_t                 lsize;
        pair_t                 lpos;
        logic [DATA_W-1:0]     stride;
        logic [DATA_W-1:0]     base_lo;
        logic [BASE_HI_W-1:0]  base_hi;
    } cfg_t;

    localparam logic [DATA_W-1:0] OPAQUE_BLACK = 32'hFF00_0000;

    function automatic logic [DATA_W-1:0] to_argb(input logic [DATA_W-1:0] w,
                                                  input logic bgra);
        return bgra ? {8'hFF, w[15:8], w[23:16], w[31:24]}
                    : {8'hFF, w[23:0]};
    endfunction

    function automatic logic [ADDR_W-1:0] base_bytes(input cfg_t c);
        return {c.base_hi, c.base_lo[DATA_W-1:FRAC_W]};
    endfunction

    function automatic logic [ADDR_W-1:0] stride_bytes(input cfg_t c);
        return {{BASE_HI_W{1'b0}}, c.stride[DATA_W-1:FRAC_W]};
    endfunction
endpackage

// File: rtl/lwc_regs.sv
module lwc_regs
    import lwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [RADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 boundary,
    output cfg_t                 cfg_eff
);
    cfg_t shadow_q, active_q;
    logic armed_q;

    // R2: the boundary pixel already sees the copied set
    assign cfg_eff = (armed_q && boundary) ? shadow_q : active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (armed_q && boundary) begin
                active_q <= shadow_q;
                armed_q  <= 1'b0;
            end
            if (we) begin
                case (reg_sel_e'(addr))
                    RG_CTRL:    shadow_q.ctrl    <= ctrl_t'(wdata[4:0]);
                    RG_DSIZE:   shadow_q.dsize   <= pair_t'(wdata);
                    RG_LSIZE:   shadow_q.lsize   <= pair_t'(wdata);
                    RG_LPOS:    shadow_q.lpos    <= pair_t'(wdata);
                    RG_STRIDE:  shadow_q.stride  <= wdata;
                    RG_BASE_LO: shadow_q.base_lo <= wdata;
                    RG_BASE_HI: shadow_q.base_hi <= wdata[BASE_HI_W-1:0];
                    RG_LOAD:    if (wdata[0]) armed_q <= 1'b1;
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lwc_pixel.sv
module lwc_pixel
    import lwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_t               cfg,
    input  logic               pix_valid,
    input  logic [CRD_W-1:0]   pix_x,
    input  logic [CRD_W-1:0]   pix_y,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_data,
    output logic               in_ready,
    output logic               row_done,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_pixel,
    output logic               underflow
);
    logic [CRD_W:0] h_last, x_end, y_end;
    logic in_disp, in_rect, running, lay_on, take;

    always_comb begin
        // R8: interlace doubles the height, last row = 2*(h-1)+1
        h_last  = cfg.ctrl.ilace ? {cfg.dsize.hi, 1'b1} : {1'b0, cfg.dsize.hi};
        x_end   = {1'b0, cfg.lpos.lo} + {1'b0, cfg.lsize.lo};
        y_end   = {1'b0, cfg.lpos.hi} + {1'b0, cfg.lsize.hi};
        in_disp = (pix_x <= cfg.dsize.lo) && ({1'b0, pix_y} <= h_last);
        in_rect = (pix_x >= cfg.lpos.lo) && ({1'b0, pix_x} <= x_end) &&
                  (pix_y >= cfg.lpos.hi) && ({1'b0, pix_y} <= y_end);
        running = cfg.ctrl.mod_en && cfg.ctrl.run;
        lay_on  = running && cfg.ctrl.lay_en && in_disp && in_rect;
        take    = pix_valid && lay_on;
    end

    assign in_ready = take;
    assign row_done = take && ({1'b0, pix_x} == x_end) && ({1'b0, pix_y} != y_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pixel <= '0;
            underflow <= 1'b0;
        end else begin
            out_valid <= pix_valid && running && in_disp;
            out_pixel <= (lay_on && in_valid) ? to_argb(in_data, cfg.ctrl.bgra)
                                              : OPAQUE_BLACK;
            if (take && !in_valid)
                underflow <= 1'b1;
        end
    end
endmodule

// File: rtl/lwc_fetch.sv
module lwc_fetch
    import lwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  cfg_t               cfg,
    input  logic               frame_go,
    input  logic               row_done,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [ADDR_W-1:0]  req_addr
);
    logic [ADDR_W-1:0] next_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= 1'b0;
            req_addr  <= '0;
            next_q    <= '0;
        end else if (frame_go) begin
            req_valid <= 1'b1;
            req_addr  <= base_bytes(cfg);
            next_q    <= base_bytes(cfg) + stride_bytes(cfg);
        end else if (row_done) begin
            req_valid <= 1'b1;
            req_addr  <= next_q;
            next_q    <= next_q + stride_bytes(cfg);
        end else if (req_valid && req_ready) begin
            req_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/lwc_top.sv
module lwc_top
    import lwc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                pix_valid,
    input  logic [15:0]         pix_x,
    input  logic [15:0]         pix_y,
    output logic                fetch_req_valid,
    input  logic                fetch_req_ready,
    output logic [32:0]         fetch_req_addr,
    input  logic                px_in_valid,
    output logic                px_in_ready,
    input  logic [31:0]         px_in_data,
    output logic                out_valid,
    output logic [31:0]         out_pixel,
    output logic                underflow
);
    cfg_t cfg;
    logic boundary, frame_go, row_done;

    assign boundary = pix_valid && (pix_x == '0) && (pix_y == '0);
    assign frame_go = boundary && cfg.ctrl.mod_en && cfg.ctrl.run && cfg.ctrl.lay_en;

    lwc_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .boundary (boundary),
        .cfg_eff  (cfg)
    );

    lwc_pixel u_pixel (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .pix_valid (pix_valid),
        .pix_x     (pix_x),
        .pix_y     (pix_y),
        .in_valid  (px_in_valid),
        .in_data   (px_in_data),
        .in_ready  (px_in_ready),
        .row_done  (row_done),
        .out_valid (out_valid),
        .out_pixel (out_pixel),
        .underflow (underflow)
    );

    lwc_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .frame_go  (frame_go),
        .row_done  (row_done),
        .req_ready (fetch_req_ready),
        .req_valid (fetch_req_valid),
        .req_addr  (fetch_req_addr)
    );
endmodule

// File: rtl/lwc_checker.sv
module lwc_checker (
    input logic        clk,
    input logic        rst,
    input logic        pix_valid,
    input logic        out_valid,
    input logic [31:0] out_pixel,
    input logic        underflow,
    input logic        in_ready,
    input logic        in_valid,
    input logic        req_valid,
    input logic        req_ready,
    input logic [32:0] req_addr
);
    AST_OUT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(pix_valid)); // R3

    AST_ALPHA_OPAQUE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_pixel[31:24] == 8'hFF)); // R5

    AST_BLACK_WITHOUT_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(in_ready && in_valid)) |-> (out_pixel == 32'hFF00_0000)); // R4

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow); // R10

    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(underflow) |-> $past(in_ready && !in_valid)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !pix_valid) |=> (req_valid && $stable(req_addr))); // R9
endmodule

bind lwc_top lwc_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_valid (pix_valid),
    .out_valid (out_valid),
    .out_pixel (out_pixel),
    .underflow (underflow),
    .in_ready  (px_in_ready),
    .in_valid  (px_in_valid),
    .req_valid (fetch_req_valid),
    .req_ready (fetch_req_ready),
    .req_addr  (fetch_req_addr)
);

// File: tb/tb_lwc_top.sv
module tb_lwc_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        pix_valid = 1'b0;
    logic [15:0] pix_x = '0, pix_y = '0;
    logic        fetch_req_valid, fetch_req_ready = 1'b0;
    logic [32:0] fetch_req_addr;
    logic        px_in_valid = 1'b0, px_in_ready;
    logic [31:0] px_in_data = '0;
    logic        out_valid, underflow;
    logic [31:0] out_pixel;

    always #4 clk = ~clk;

    lwc_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_req_addr(fetch_req_addr), .px_in_valid(px_in_valid),
        .px_in_ready(px_in_ready), .px_in_data(px_in_data),
        .out_valid(out_valid), .out_pixel(out_pixel), .underflow(underflow)
    );

    int checks = 0, errors = 0, cyc = 0, ov_count = 0;
    bit done = 1'b0;
    logic [31:0] m_sh [8];
    logic [31:0] m_act [8];
    bit m_armed = 1'b0;
    bit e_ov = 1'b0, e_uf = 1'b0, e_rv = 1'b0;
    logic [31:0] e_px = '0;
    longint e_ra = 0;
    logic [31:0] dq [$];

    function automatic logic [31:0] wgen(longint a);
        return (32'(a) * 32'h0001_0003) ^ 32'h5A00_00C3;
    endfunction

    function automatic logic [31:0] conv(logic [31:0] w, bit bg);
        logic [7:0] r, g, b;
        if (bg) begin b = w[31:24]; g = w[23:16]; r = w[15:8]; end
        else    begin r = w[23:16]; g = w[15:8];  b = w[7:0];  end
        return {8'hFF, r, g, b};
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        logic [31:0] e [8];
        bit bnd, mo, le, rn, il, bg, indisp, inlay, act, layon, rdy, fgo, rdone, xfer;
        int x, y, W, H, LW, LH, LX, LY;
        longint base, sb, req_served;
        bit n_ov, n_uf, n_rv;
        logic [31:0] n_px;
        longint n_ra;
        string ptag;

        px_in_valid = (dq.size() > 0);
        px_in_data  = (dq.size() > 0) ? dq[0] : 32'h0;
        fetch_req_ready = ((cyc % 3) != 1);
        cyc++;
        #1;
        x = int'(pix_x); y = int'(pix_y);
        bnd = pix_valid && x == 0 && y == 0;
        for (int i = 0; i < 8; i++) e[i] = (m_armed && bnd) ? m_sh[i] : m_act[i];
        mo = e[0][0]; le = e[0][1]; rn = e[0][2]; il = e[0][3]; bg = e[0][4];
        W  = int'(e[1][15:0]) + 1;
        H  = (int'(e[1][31:16]) + 1) * (il ? 2 : 1);
        LW = int'(e[2][15:0]) + 1;  LH = int'(e[2][31:16]) + 1;
        LX = int'(e[3][15:0]);      LY = int'(e[3][31:16]);
        base = (longint'(e[6][3:0]) << 29) | longint'(e[5] >> 3);
        sb   = longint'(e[4] >> 3);
        indisp = x < W && y < H;
        inlay  = x >= LX && x < LX + LW && y >= LY && y < LY + LH;
        act    = mo && rn;
        layon  = act && le && indisp && inlay;
        rdy    = pix_valid && layon;
        chk(px_in_ready === rdy, "R6", "px_in_ready", px_in_ready, rdy);

        n_ov = pix_valid && act && indisp;
        n_px = (layon && px_in_valid) ? conv(px_in_data, bg) : 32'hFF00_0000;
        ptag = !layon ? "R4" : (!px_in_valid ? "R10" : (bg ? "R5" : "R6"));
        n_uf = e_uf || (rdy && !px_in_valid);
        xfer = e_rv && fetch_req_ready;
        req_served = e_ra;
        fgo   = bnd && act && le;
        rdone = rdy && x == LX + LW - 1 && y != LY + LH - 1;
        n_rv = e_rv; n_ra = e_ra;
        if (fgo)        begin n_rv = 1'b1; n_ra = base; end
        else if (rdone) begin n_rv = 1'b1; n_ra = base + longint'(y - LY + 1) * sb; end
        else if (xfer)    n_rv = 1'b0;
        if (rdy && px_in_valid) void'(dq.pop_front());
        if (xfer) for (int i = 0; i < LW; i++) dq.push_back(wgen(req_served + 4 * i));
        if (bnd && m_armed) begin
            for (int i = 0; i < 8; i++) m_act[i] = m_sh[i];
            m_armed = 1'b0;
        end
        if (cfg_we) begin
            if (cfg_addr == 3'd7) begin if (cfg_wdata[0]) m_armed = 1'b1; end
            else m_sh[cfg_addr] = cfg_wdata;
        end

        @(posedge clk);
        @(negedge clk);
        chk(out_valid === n_ov, "R3", "out_valid", out_valid, n_ov);
        if (n_ov) chk(out_pixel === n_px, ptag, "out_pixel", out_pixel, n_px);
        chk(underflow === n_uf, "R10", "underflow", underflow, n_uf);
        chk(fetch_req_valid === n_rv, "R9", "fetch_req_valid", fetch_req_valid, n_rv);
        if (n_rv) chk(longint'(fetch_req_addr) == n_ra, "R9", "fetch_req_addr",
                      longint'(fetch_req_addr), n_ra);
        if (out_valid) ov_count++;
        e_ov = n_ov; e_px = n_px; e_uf = n_uf; e_rv = n_rv; e_ra = n_ra;
        cfg_we = 1'b0;
    endtask

    task automatic wr(int a, logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d; pix_valid = 1'b0;
        cycle();
    endtask

    task automatic frame(int cols, int rows, int gap);
        ov_count = 0;
        for (int y = 0; y < rows; y++) begin
            for (int x = 0; x < cols; x++) begin
                pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y);
                cycle();
            end
            pix_valid = 1'b0;
            repeat (gap) cycle();
        end
    endtask

    task automatic load();
        wr(7, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", "reset out_valid", out_valid, 0);
        chk(fetch_req_valid === 1'b0, "R1", "reset fetch_req_valid", fetch_req_valid, 0);
        chk(underflow === 1'b0, "R1", "reset underflow", underflow, 0);
        chk(px_in_ready === 1'b0, "R1", "reset px_in_ready", px_in_ready, 0);
        rst = 1'b0;

        // R1/R2: programmed but not loaded -> nothing shown
        wr(1, (32'd3 << 16) | 32'd9);
        wr(2, (32'd1 << 16) | 32'd3);
        wr(3, (32'd1 << 16) | 32'd3);
        wr(4, 32'd512);
        wr(5, 32'h0000_8000);
        wr(6, 32'h0);
        wr(0, 32'h7);
        frame(12, 5, 6);
        chk(ov_count == 0, "R2", "pixels before load", ov_count, 0);

        // R3/R6/R9: normal frame
        load();
        frame(12, 5, 6);
        chk(ov_count == 40, "R3", "pixels per frame", ov_count, 40);
        chk(dq.size() == 0, "R9", "words left over", dq.size(), 0);
        chk(underflow === 1'b0, "R10", "no underflow when fed", underflow, 0);

        // R5: other byte order
        wr(0, 32'h17); load();
        frame(12, 5, 6);
        chk(ov_count == 40, "R5", "pixels per frame bgra", ov_count, 40);

        // R8: interlace doubles height
        wr(0, 32'hF); load();
        frame(12, 9, 6);
        chk(ov_count == 80, "R8", "pixels per interlaced frame", ov_count, 80);

        // R9: new base with high bits and new stride loaded on the boundary edge
        wr(5, 32'hFFFF_FFF8); wr(6, 32'h3); wr(4, 32'd320); wr(0, 32'h7); load();
        frame(12, 5, 6);
        chk(dq.size() == 0, "R9", "words left after rebased frame", dq.size(), 0);

        // R4: layer disabled, all black
        wr(0, 32'h5); load();
        frame(12, 5, 6);
        chk(ov_count == 40, "R4", "pixels with layer off", ov_count, 40);

        // R7: run bit clear, no output
        wr(0, 32'h3); load();
        frame(12, 5, 6);
        chk(ov_count == 0, "R7", "pixels while stopped", ov_count, 0);

        // R10: layer at origin starves its first pixel
        wr(3, 32'h0); wr(0, 32'h7); load();
        frame(12, 5, 6);
        chk(underflow === 1'b1, "R10", "underflow after starved pixel", underflow, 1);
        repeat (4) cycle();
        chk(underflow === 1'b1, "R10", "underflow sticky", underflow, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule